// File: doc/BRIEF.md
# Row-Burst Backed Packet Word Queue

This block is a deep first-in first-out queue for packet words. Most of its capacity sits in a bulk store that models dense memory. The bulk store accepts only whole bursts of consecutive words inside one row, and each burst starts only after a fixed access delay that is several word times long. Two small fast ring buffers carry the per-word traffic, one on the write side and one on the read side. The write-side ring gathers incoming words until a full burst is ready. The read-side ring asks for a burst as soon as it has room for one, so that the consumer is not exposed to the bulk store's access delay.

A scheduler looks at how full the two rings and the bulk store are, and starts at most one bulk transfer at a time. When the bulk store holds nothing and no transfer is in progress, words move straight from the write-side ring to the read-side ring, one per cycle, without touching the bulk store. This keeps pop latency short for a lightly loaded queue. Word order is preserved across all three storage regions. The access delay is modelled inside the block by a cycle counter.

Top module: `cached_pkt_fifo`

## Requirements
- R1: While reset is held and once it is released, `fifo_empty` is 1, `fifo_full` is 0, `push_ready` is 1 and `pop_valid` is 0.
- R2: Words leave on the pop side in exactly the order in which they were accepted on the push side, whatever mix of write-side ring, bulk store and read-side ring they passed through.
- R3: With the queue empty, a word accepted at clock edge k makes `pop_valid` 1 with that word on `pop_data` after edge k+1, and `pop_valid` is still 0 between edges k and k+1.
- R4: A write into the bulk store starts only when the write-side ring holds at least `BURST` words, and each write moves exactly `BURST` words into one row.
- R5: A read from the bulk store starts only when the bulk store holds at least one row and the read-side ring has at least `BURST` free slots. The read-side ring never overflows.
- R6: The first word of any bulk burst moves exactly `LAT` cycles after the cycle in which the burst command is accepted, plus the one cycle that starts the burst. For a queue holding `HEAD_DEPTH` words in the read-side ring and one row in bulk, draining with `pop_ready` held at 1 takes exactly 2*`BURST`+`LAT`+2 cycles.
- R7: Words move directly from the write-side ring to the read-side ring only while the bulk store is empty and no bulk transfer is in progress.
- R8: `push_ready` is 0 exactly when the write-side ring is full. Under pushes without pops, the queue accepts exactly `TAIL_DEPTH`+`ROWS`*`BURST`+`HEAD_DEPTH` words. It then raises `fifo_full`, and the bulk row count never exceeds `ROWS`.
- R9: Whenever any region holds data, `pop_valid` is 0 for at most 2*(`LAT`+`BURST`)+4 consecutive cycles.
- R10: While `pop_valid` is 1 and `pop_ready` is 0, `pop_valid` stays 1 and `pop_data` does not change on the next cycle.
- R11: `fifo_empty` is 1 exactly when no region holds a word and no bulk transfer is in progress. It is 0 while words sit only in the bulk store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | A word is offered on `push_data` |
| push_ready | output | 1 | The queue can take a word this cycle |
| push_data | input | W | Word to store |
| pop_valid | output | 1 | `pop_data` carries the oldest word |
| pop_ready | input | 1 | The consumer takes the word this cycle |
| pop_data | output | W | Oldest stored word |
| fifo_empty | output | 1 | No word anywhere in the queue |
| fifo_full | output | 1 | Every region is at capacity |

## Verification
The hardest state to reach from the ports is the one where the read-side ring runs dry while the next words are still behind the bulk store's access delay. The order and timing of that refill are what R2, R6 and R9 depend on. The bench reaches this state in a directed way. It pushes exactly one read-side ring plus one burst with no pops, waits for the burst to land in the bulk store, and then pops without a break, so that the ring empties before the prefetch arrives. Separate runs fill every region to capacity, and use pattern-gated push and pop rates that force the bulk store to alternate between read and write bursts.

// File: rtl/cpf_pkg.sv
`timescale 1ns/1ps
package cpf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_BURST = 2'd2
  } bulk_phase_e;
endpackage

// File: rtl/cpf_ring.sv
`timescale 1ns/1ps
// Small fast ring buffer with occupancy count; used on both sides of the bulk store.
module cpf_ring #(
  parameter int W = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop && !push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wr_q] <= wdata;
    end
  end

  assign rdata = mem_q[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/cpf_bulk.sv
`timescale 1ns/1ps
// Row-burst bulk store: a command waits LAT cycles, then BURST words move one per cycle.
module cpf_bulk
  import cpf_pkg::*;
#(
  parameter int W = 32,
  parameter int B = 4,
  parameter int ROWS = 8,
  parameter int LAT = 6,
  localparam int RW = $clog2(ROWS),
  localparam int BW = $clog2(B),
  localparam int LW = $clog2(LAT + 1),
  localparam int DEPTH = ROWS * B,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_wr,
  input  logic [RW-1:0] cmd_row,
  output logic          cmd_take,
  output logic          busy,
  output logic          wr_beat,
  input  logic [W-1:0]  wr_data,
  output logic          rd_beat,
  output logic [W-1:0]  rd_data
);
  bulk_phase_e   phase_q, phase_d;
  logic [RW-1:0] row_q, row_d;
  logic          dir_q, dir_d;
  logic [LW-1:0] lat_q, lat_d;
  logic [BW-1:0] beat_q, beat_d;
  logic [AW-1:0] addr;
  logic [W-1:0]  mem_q [DEPTH];

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    dir_d   = dir_q;
    lat_d   = lat_q;
    beat_d  = beat_q;
    case (phase_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          phase_d = PH_WAIT;
          row_d   = cmd_row;
          dir_d   = cmd_wr;
          lat_d   = LW'(LAT - 1);
          beat_d  = '0;
        end
      end
      PH_WAIT: begin
        if (lat_q == '0) begin
          phase_d = PH_BURST;
        end else begin
          lat_d = lat_q - 1'b1;
        end
      end
      PH_BURST: begin
        beat_d = beat_q + 1'b1;
        if (beat_q == BW'(B - 1)) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      dir_q   <= 1'b0;
      lat_q   <= '0;
      beat_q  <= '0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      dir_q   <= dir_d;
      lat_q   <= lat_d;
      beat_q  <= beat_d;
    end
  end

  assign addr     = AW'(row_q) * AW'(B) + AW'(beat_q);
  assign cmd_take = (phase_q == PH_IDLE) && cmd_valid;
  assign busy     = (phase_q != PH_IDLE);
  assign wr_beat  = (phase_q == PH_BURST) && dir_q;
  assign rd_beat  = (phase_q == PH_BURST) && !dir_q;
  assign rd_data  = mem_q[addr];

  always_ff @(posedge clk) begin
    if (wr_beat) begin
      mem_q[addr] <= wr_data;
    end
  end
endmodule

// File: rtl/cpf_sched.sv
`timescale 1ns/1ps
// Picks one bulk transfer or a direct move per cycle and tracks bulk row occupancy.
module cpf_sched #(
  parameter int B = 4,
  parameter int ROWS = 8,
  parameter int TD = 8,
  parameter int HD = 8,
  localparam int RW = $clog2(ROWS),
  localparam int RCW = $clog2(ROWS + 1),
  localparam int TCW = $clog2(TD + 1),
  localparam int HCW = $clog2(HD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TCW-1:0] tail_cnt,
  input  logic [HCW-1:0] head_cnt,
  input  logic           busy,
  output logic           cmd_valid,
  output logic           cmd_wr,
  output logic [RW-1:0]  cmd_row,
  output logic           bypass,
  output logic [RCW-1:0] rows
);
  logic [RCW-1:0] rows_q, rows_d;
  logic [RW-1:0]  wrow_q, wrow_d, rrow_q, rrow_d;
  logic           head_room, head_full, tail_burst;
  logic           want_rd, want_wr, can_byp;

  function automatic logic [RW-1:0] bump(input logic [RW-1:0] p);
    return (p == RW'(ROWS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_room  = (head_cnt <= HCW'(HD - B));
    head_full  = (head_cnt == HCW'(HD));
    tail_burst = (tail_cnt >= TCW'(B));
    want_rd    = (rows_q != '0) && head_room;
    want_wr    = tail_burst && (rows_q != RCW'(ROWS)) && ((rows_q != '0) || head_full);
    can_byp    = (rows_q == '0) && (tail_cnt != '0) && !head_full;

    cmd_valid = 1'b0;
    cmd_wr    = 1'b0;
    bypass    = 1'b0;
    if (!busy) begin
      if (want_rd) begin
        cmd_valid = 1'b1;
      end else if (want_wr) begin
        cmd_valid = 1'b1;
        cmd_wr    = 1'b1;
      end else begin
        bypass = can_byp;
      end
    end
    cmd_row = cmd_wr ? wrow_q : rrow_q;

    rows_d = rows_q;
    wrow_d = wrow_q;
    rrow_d = rrow_q;
    if (cmd_valid && cmd_wr) begin
      rows_d = rows_q + 1'b1;
      wrow_d = bump(wrow_q);
    end else if (cmd_valid) begin
      rows_d = rows_q - 1'b1;
      rrow_d = bump(rrow_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= '0;
      wrow_q <= '0;
      rrow_q <= '0;
    end else begin
      rows_q <= rows_d;
      wrow_q <= wrow_d;
      rrow_q <= rrow_d;
    end
  end

  assign rows = rows_q;
endmodule

// File: rtl/cached_pkt_fifo.sv
`timescale 1ns/1ps
module cached_pkt_fifo #(
  parameter int W = 32,
  parameter int BURST = 4,
  parameter int ROWS = 8,
  parameter int LAT = 6,
  parameter int TAIL_DEPTH = 8,
  parameter int HEAD_DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data,
  output logic         fifo_empty,
  output logic         fifo_full
);
  localparam int TCW = $clog2(TAIL_DEPTH + 1);
  localparam int HCW = $clog2(HEAD_DEPTH + 1);
  localparam int RCW = $clog2(ROWS + 1);
  localparam int RW  = $clog2(ROWS);

  logic           rst_s0, rst_q;
  logic [TCW-1:0] tail_cnt;
  logic [HCW-1:0] head_cnt;
  logic [RCW-1:0] rows;
  logic [RW-1:0]  cmd_row;
  logic [W-1:0]   tail_rdata, bulk_rdata, head_wdata;
  logic           tail_full, tail_empty, head_full, head_empty;
  logic           tail_push, tail_pop, head_push, head_pop;
  logic           cmd_valid, cmd_wr, cmd_take, busy, bypass, wr_beat, rd_beat;

  // Reset asserts at once, deasserts on the second rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_q  <= rst_s0;
    end
  end

  assign tail_push  = push_valid && !tail_full;
  assign tail_pop   = bypass || wr_beat;
  assign head_push  = bypass || rd_beat;
  assign head_pop   = !head_empty && pop_ready;
  assign head_wdata = rd_beat ? bulk_rdata : tail_rdata;

  cpf_ring #(.W(W), .DEPTH(TAIL_DEPTH)) u_tail (
    .clk   (clk),
    .rst_n (rst_q),
    .push  (tail_push),
    .wdata (push_data),
    .pop   (tail_pop),
    .rdata (tail_rdata),
    .count (tail_cnt),
    .full  (tail_full),
    .empty (tail_empty)
  );

  cpf_sched #(.B(BURST), .ROWS(ROWS), .TD(TAIL_DEPTH), .HD(HEAD_DEPTH)) u_sched (
    .clk       (clk),
    .rst_n     (rst_q),
    .tail_cnt  (tail_cnt),
    .head_cnt  (head_cnt),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .cmd_wr    (cmd_wr),
    .cmd_row   (cmd_row),
    .bypass    (bypass),
    .rows      (rows)
  );

  cpf_bulk #(.W(W), .B(BURST), .ROWS(ROWS), .LAT(LAT)) u_bulk (
    .clk       (clk),
    .rst_n     (rst_q),
    .cmd_valid (cmd_valid),
    .cmd_wr    (cmd_wr),
    .cmd_row   (cmd_row),
    .cmd_take  (cmd_take),
    .busy      (busy),
    .wr_beat   (wr_beat),
    .wr_data   (tail_rdata),
    .rd_beat   (rd_beat),
    .rd_data   (bulk_rdata)
  );

  cpf_ring #(.W(W), .DEPTH(HEAD_DEPTH)) u_head (
    .clk   (clk),
    .rst_n (rst_q),
    .push  (head_push),
    .wdata (head_wdata),
    .pop   (head_pop),
    .rdata (pop_data),
    .count (head_cnt),
    .full  (head_full),
    .empty (head_empty)
  );

  assign push_ready = !tail_full;
  assign pop_valid  = !head_empty;
  assign fifo_empty = tail_empty && head_empty && (rows == '0) && !busy;
  assign fifo_full  = tail_full && head_full && (rows == RCW'(ROWS)) && !busy;
endmodule

// File: rtl/cpf_checker.sv
`timescale 1ns/1ps
module cpf_checker #(
  parameter int W = 32,
  parameter int B = 4,
  parameter int ROWS = 8,
  parameter int LAT = 6,
  parameter int TD = 8,
  parameter int HD = 8,
  localparam int TCW = $clog2(TD + 1),
  localparam int HCW = $clog2(HD + 1),
  localparam int RCW = $clog2(ROWS + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pop_valid,
  input logic           pop_ready,
  input logic [W-1:0]   pop_data,
  input logic           fifo_empty,
  input logic [TCW-1:0] tail_cnt,
  input logic [HCW-1:0] head_cnt,
  input logic [RCW-1:0] rows,
  input logic           busy,
  input logic           cmd_take,
  input logic           cmd_wr,
  input logic           bypass,
  input logic           wr_beat,
  input logic           rd_beat
);
  localparam logic [15:0] STARVE_MAX = 16'(2 * (LAT + B) + 4);
  logic [15:0] wait_q, starve_q;
  logic        any_beat;

  assign any_beat = wr_beat || rd_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q   <= '0;
      starve_q <= '0;
    end else begin
      if (cmd_take) begin
        wait_q <= '0;
      end else if (busy && !any_beat && (wait_q != 16'hFFFF)) begin
        wait_q <= wait_q + 1'b1;
      end
      if (fifo_empty || pop_valid) begin
        starve_q <= '0;
      end else if (starve_q != 16'hFFFF) begin
        starve_q <= starve_q + 1'b1;
      end
    end
  end

  // R4
  burst_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && cmd_wr) |-> (tail_cnt >= TCW'(B)));
  // R4
  wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |-> (tail_cnt != '0));
  // R5
  rd_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && !cmd_wr) |-> ((rows != '0) && (head_cnt <= HCW'(HD - B))));
  // R5
  head_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |-> (head_cnt < HCW'(HD)));
  // R6
  access_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_beat) |-> (wait_q == 16'(LAT)));
  // R7
  direct_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> ((rows == '0) && !busy));
  // R8
  row_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rows <= RCW'(ROWS));
  // R9
  pop_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    starve_q <= STARVE_MAX);
  // R10
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)));
endmodule

bind cached_pkt_fifo cpf_checker #(
  .W(W), .B(BURST), .ROWS(ROWS), .LAT(LAT), .TD(TAIL_DEPTH), .HD(HEAD_DEPTH)
) u_cpf_checker (
  .clk        (clk),
  .rst_n      (rst_q),
  .pop_valid  (pop_valid),
  .pop_ready  (pop_ready),
  .pop_data   (pop_data),
  .fifo_empty (fifo_empty),
  .tail_cnt   (tail_cnt),
  .head_cnt   (head_cnt),
  .rows       (rows),
  .busy       (busy),
  .cmd_take   (cmd_take),
  .cmd_wr     (cmd_wr),
  .bypass     (bypass),
  .wr_beat    (wr_beat),
  .rd_beat    (rd_beat)
);

// File: tb/test_cached_pkt_fifo.sv
`timescale 1ns/1ps
module test_cached_pkt_fifo;
  localparam int W = 32;
  localparam int B = 4;
  localparam int ROWS = 8;
  localparam int LAT = 6;
  localparam int TD = 8;
  localparam int HD = 8;
  localparam int CAP = TD + ROWS * B + HD;
  localparam int STARVE_MAX = 2 * (LAT + B) + 4;

  logic         clk, rst_n;
  logic         push_valid, push_ready, pop_valid, pop_ready, fifo_empty, fifo_full;
  logic [W-1:0] push_data, pop_data;

  int           n_chk, n_bad, n_acc, gap, max_gap;
  logic [W-1:0] model[$];
  logic [W-1:0] next_val, step_val;
  logic [15:0]  lfsr;
  bit           done;

  cached_pkt_fifo #(
    .W(W), .BURST(B), .ROWS(ROWS), .LAT(LAT), .TAIL_DEPTH(TD), .HEAD_DEPTH(HD)
  ) i_cached_pkt_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .pop_data   (pop_data),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // One clock: drive at a falling edge, judge the handshake, move to the next falling edge.
  task automatic cycle(input bit pv, input bit pr, input string req);
    push_valid = pv;
    push_data  = next_val;
    pop_ready  = pr;
    #1;
    if (pv && push_ready) begin
      model.push_back(next_val);
      next_val = next_val + step_val;
      n_acc++;
    end
    if (pr && pop_valid) begin
      if (model.size() == 0) begin
        check(1'b0, req, pop_data, '0);
      end else begin
        check(pop_data == model[0], req, pop_data, model[0]);
        void'(model.pop_front());
      end
    end
    if (model.size() != 0 && !pop_valid) gap++;
    else gap = 0;
    if (gap > max_gap) max_gap = gap;
    @(negedge clk);
    push_valid = 1'b0;
    pop_ready  = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 2000 && model.size() != 0; i++) begin
      cycle(1'b0, 1'b1, req);
    end
    check(model.size() == 0, req, W'(model.size()), '0);
    check(fifo_empty == 1'b1, "R11 empty after drain", W'(fifo_empty), 1);
    check(pop_valid == 1'b0, "R11 no pop after drain", W'(pop_valid), 0);
  endtask

  task automatic t_reset;
    check(push_ready == 1'b1, "R1 push_ready", W'(push_ready), 1);
    check(pop_valid == 1'b0, "R1 pop_valid", W'(pop_valid), 0);
    check(fifo_empty == 1'b1, "R1 fifo_empty", W'(fifo_empty), 1);
    check(fifo_full == 1'b0, "R1 fifo_full", W'(fifo_full), 0);
  endtask

  task automatic t_direct;
    logic [W-1:0] word;
    word = 32'hC0DE_0001;
    push_valid = 1'b1;
    push_data  = word;
    @(negedge clk);
    push_valid = 1'b0;
    check(pop_valid == 1'b0, "R3 not yet after accept edge", W'(pop_valid), 0);
    @(negedge clk);
    check(pop_valid == 1'b1, "R3 valid after next edge", W'(pop_valid), 1);
    check(pop_data == word, "R3 word", pop_data, word);
    // R10: hold without pop_ready
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(pop_valid == 1'b1 && pop_data == word, "R10 held while stalled", pop_data, word);
    end
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
    check(fifo_empty == 1'b1, "R11 empty after single pop", W'(fifo_empty), 1);
  endtask

  // mode 0: balanced, mode 1: heavy push, mode 2: heavy pop
  task automatic t_stream(input int mode, input int len, input string req);
    bit pv, pr;
    next_val = 32'h1000_0000 * (mode + 1);
    step_val = 32'h0001_0003 + mode;
    gap = 0;
    max_gap = 0;
    for (int i = 0; i < len; i++) begin
      lfsr = lfsr_next(lfsr);
      case (mode)
        0: begin pv = lfsr[0]; pr = lfsr[3]; end
        1: begin pv = 1'b1; pr = (lfsr[2:1] == 2'b00); end
        default: begin pv = (lfsr[2:1] == 2'b01); pr = 1'b1; end
      endcase
      cycle(pv, pr, req);
    end
    drain(req);
    check(max_gap <= STARVE_MAX, "R9 pop gap bound", W'(max_gap), W'(STARVE_MAX));
  endtask

  task automatic t_fill;
    next_val = 32'hF111_0000;
    step_val = 32'h0000_0101;
    n_acc = 0;
    for (int i = 0; i < 300; i++) cycle(1'b1, 1'b0, "R8 fill");
    check(n_acc == CAP, "R8 accepted words", W'(n_acc), W'(CAP));
    check(push_ready == 1'b0, "R8 push_ready when full", W'(push_ready), 0);
    check(fifo_full == 1'b1, "R8 fifo_full", W'(fifo_full), 1);
    check(fifo_empty == 1'b0, "R11 not empty when full", W'(fifo_empty), 0);
    gap = 0;
    max_gap = 0;
    drain("R2 R4 R5 order through bulk");
    check(max_gap <= STARVE_MAX, "R9 pop gap during drain", W'(max_gap), W'(STARVE_MAX));
  endtask

  // Read ring full, one row in bulk, then pop without a break.
  task automatic t_refill_timing;
    int cnt;
    next_val = 32'h5A00_0000;
    step_val = 32'h0000_0011;
    for (int i = 0; i < HD + B; i++) cycle(1'b1, 1'b0, "R6 setup");
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, "R6 settle");
    check(fifo_empty == 1'b0, "R11 not empty with bulk data", W'(fifo_empty), 0);
    check(fifo_full == 1'b0, "R8 not full when partial", W'(fifo_full), 0);
    cnt = 0;
    while (model.size() != 0 && cnt < 200) begin
      cycle(1'b0, 1'b1, "R2 R5 R6 refill order");
      cnt++;
    end
    check(cnt == 2 * B + LAT + 2, "R6 drain cycles", W'(cnt), W'(2 * B + LAT + 2));
    check(fifo_empty == 1'b1, "R11 empty after refill drain", W'(fifo_empty), 1);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    n_acc = 0;
    done = 1'b0;
    lfsr = 16'hACE1;
    next_val = '0;
    step_val = 32'd1;
    rst_n = 1'b0;
    push_valid = 1'b0;
    pop_ready = 1'b0;
    push_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_stream(0, 400, "R2 R7 balanced");
    t_stream(1, 300, "R2 R4 R5 heavy push");
    t_stream(2, 300, "R2 R7 heavy pop");
    t_fill();
    t_refill_timing();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule